// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block sits beside a processor core and turns a pending event into the register updates that start its handler. Each cycle it looks at a pending exception code, a hard-interrupt request with the vector already chosen by the interrupt controller, and the core's current status word, program counter, vector base and stack register. It decides whether the event is taken. For a taken event it produces, in one registered update, the saved copies of status, PC and stack register, the new status word, the event code to record and the handler address.

Exceptions always win over interrupts. The status block bit changes what happens. While it is set, an exception is replaced by the reset code, except for one code that is kept. An interrupt is dropped while the block bit is set, unless the core is asleep. Three handler offsets above the vector base, plus a fixed reset vector, are chosen by event class. The saved PC is moved back for a fault in a branch delay slot and moved forward for a trap instruction.

The core loads its registers from the outputs during the cycle in which `accept_o` is high. The outputs keep their values until the next taken event.

Top module: `evt_entry_top`

## Requirements
- R1: A pending exception is always taken in the cycle it is presented, even when an interrupt request is present in the same cycle. In that case the interrupt event output keeps its previous value.
- R2: Status bit 28 is the block bit. While it is set, any exception code other than 0x1E0 is recorded and dispatched as code 0x000. Code 0x1E0 passes through unchanged.
- R3: While the block bit is set, an interrupt request is not taken and all outputs hold, unless the sleep flag is set. With the sleep flag set, the interrupt is taken.
- R4: On a taken event, the saved status equals the incoming status and the saved stack register equals the incoming general register 15. The new status is the incoming status with bits 28 (block), 29 (register bank) and 30 (privileged mode) set.
- R5: When the in-delay-slot input is high for a taken event, the saved PC is the incoming PC minus 2 and `delay_clr_o` pulses for that update. Otherwise the saved PC is the incoming PC and `delay_clr_o` stays low.
- R6: The effective exception codes 0x000, 0x020 and 0x140 jump to 0xA0000000. For these codes the new status also has bit 15 (FPU disable) cleared and bits 7:4 (interrupt mask) forced to 0xF.
- R7: Codes 0x040 and 0x060 jump to vector base + 0x400. Every other exception code jumps to vector base + 0x100.
- R8: For code 0x160 (trap) the saved PC gets an extra +2. When that code arrives in a delay slot, the saved PC equals the incoming PC.
- R9: A taken interrupt loads its vector into the interrupt event output and jumps to vector base + 0x600, leaving the exception event output unchanged. A taken exception loads its effective code into the exception event output and leaves the interrupt event output unchanged.
- R10: `accept_o` is high for exactly the one cycle after the edge that captured the taken event. All other outputs change only on that edge and then hold.
- R11: A `sleep_i` pulse sets `asleep_o` on the next edge. Any taken event clears it.
- R12: After reset, all saved registers, event outputs and the handler address are zero, `asleep_o` is low, and the new status has only bits 28 and 30 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exc_pending_i | input | 1 | An exception is pending this cycle |
| exc_code_i | input | 12 | Code of the pending exception |
| irq_valid_i | input | 1 | The interrupt controller offers an unmasked vector |
| irq_vector_i | input | 12 | Offered interrupt vector |
| sleep_i | input | 1 | Core enters its sleep state |
| in_delay_slot_i | input | 1 | Current instruction is in a branch delay slot |
| cur_sr_i | input | 32 | Current status word |
| cur_pc_i | input | 32 | Current program counter |
| vbr_i | input | 32 | Vector base |
| gpr15_i | input | 32 | Current general register 15 |
| accept_o | output | 1 | One-cycle strobe: outputs carry a new entry |
| delay_clr_o | output | 1 | Core clears its delay-slot flags |
| handler_pc_o | output | 32 | Handler address to load into PC |
| new_sr_o | output | 32 | Status word to load |
| saved_sr_o | output | 32 | Saved status |
| saved_pc_o | output | 32 | Saved program counter |
| saved_gpr_o | output | 32 | Saved general register 15 |
| exc_event_o | output | 12 | Last recorded exception code |
| int_event_o | output | 12 | Last recorded interrupt vector |
| asleep_o | output | 1 | Sleep flag |

## Verification
The bench builds the block with its default 32-bit addresses and 12-bit codes. It sweeps every 0x20-aligned exception code (128 codes) under each combination of block bit and delay slot, with an interrupt raised alongside on half of them. This covers each dispatch class, the 0x1E0 exemption, the trap advance combined with a delay-slot rewind, and exception priority. Directed interrupt events then go through every combination of block bit and sleep flag. After each event an idle cycle confirms that the strobe drops and the outputs hold.

// File: rtl/evt_entry_pkg.sv
// Package: shared widths, status bit positions, event codes and event kind.
// Assumes a 32-bit core status word with the bit layout given below.
package evt_entry_pkg;
    localparam int ADDR_W   = 32;
    localparam int CODE_W   = 12;

    localparam int SR_FD    = 15;
    localparam int SR_BL    = 28;
    localparam int SR_RB    = 29;
    localparam int SR_MD    = 30;
    localparam int IMASK_LO = 4;
    localparam int IMASK_W  = 4;

    localparam logic [CODE_W-1:0] C_POWER   = CODE_W'('h000);
    localparam logic [CODE_W-1:0] C_MANUAL  = CODE_W'('h020);
    localparam logic [CODE_W-1:0] C_MULTI   = CODE_W'('h140);
    localparam logic [CODE_W-1:0] C_MISS_RD = CODE_W'('h040);
    localparam logic [CODE_W-1:0] C_MISS_WR = CODE_W'('h060);
    localparam logic [CODE_W-1:0] C_TRAP    = CODE_W'('h160);
    localparam logic [CODE_W-1:0] C_KEEP    = CODE_W'('h1E0);

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_EXC  = 2'd1,
        EV_IRQ  = 2'd2
    } ev_kind_e;
endpackage

// File: rtl/entry_arbiter.sv
// Module: entry_arbiter
// Decides which event, if any, is taken this cycle and what its effective
// code is. Assumes the interrupt request already passed the mask test.
module entry_arbiter
    import evt_entry_pkg::*;
#(
    parameter int CW = CODE_W
) (
    input  logic          exc_pending_i,
    input  logic [CW-1:0] exc_code_i,
    input  logic          irq_valid_i,
    input  logic          blocked_i,
    input  logic          asleep_i,
    output logic          take_o,
    output ev_kind_e      kind_o,
    output logic [CW-1:0] code_o
);
    // Priority: exception first; a blocked exception turns into reset
    always_comb begin
        kind_o = EV_NONE;
        code_o = exc_code_i;
        if (exc_pending_i) begin
            kind_o = EV_EXC;
            if (blocked_i && (exc_code_i != CW'(C_KEEP)))
                code_o = CW'(C_POWER);
        end else if (irq_valid_i && (!blocked_i || asleep_i)) begin
            kind_o = EV_IRQ;
        end
    end

    // Any kind other than none is a taken event
    assign take_o = (kind_o != EV_NONE);
endmodule

// File: rtl/entry_target.sv
// Module: entry_target
// Picks the handler address by event class and forms the new status word.
// Assumes the effective code has already been through block-bit masking.
module entry_target
    import evt_entry_pkg::*;
#(
    parameter int              AW        = ADDR_W,
    parameter int              CW        = CODE_W,
    parameter logic [AW-1:0]   OFS_GEN   = AW'('h100),
    parameter logic [AW-1:0]   OFS_MISS  = AW'('h400),
    parameter logic [AW-1:0]   OFS_IRQ   = AW'('h600),
    parameter logic [AW-1:0]   RESET_VEC = AW'('hA000_0000)
) (
    input  ev_kind_e      kind_i,
    input  logic [CW-1:0] code_i,
    input  logic [AW-1:0] vbr_i,
    input  logic [AW-1:0] sr_i,
    output logic [AW-1:0] handler_o,
    output logic [AW-1:0] new_sr_o
);
    logic reset_class;
    logic miss_class;

    // Classify the exception code into reset-like and TLB-miss classes
    always_comb begin
        reset_class = (kind_i == EV_EXC) &&
                      ((code_i == CW'(C_POWER)) || (code_i == CW'(C_MANUAL)) ||
                       (code_i == CW'(C_MULTI)));
        miss_class  = (kind_i == EV_EXC) &&
                      ((code_i == CW'(C_MISS_RD)) || (code_i == CW'(C_MISS_WR)));
    end

    // Handler address selection
    always_comb begin
        if (kind_i == EV_IRQ)
            handler_o = vbr_i + OFS_IRQ;
        else if (reset_class)
            handler_o = RESET_VEC;
        else if (miss_class)
            handler_o = vbr_i + OFS_MISS;
        else
            handler_o = vbr_i + OFS_GEN;
    end

    // New status: privileged, blocked, bank 1; reset class also reinitialises
    always_comb begin
        new_sr_o        = sr_i;
        new_sr_o[SR_BL] = 1'b1;
        new_sr_o[SR_RB] = 1'b1;
        new_sr_o[SR_MD] = 1'b1;
        if (reset_class) begin
            new_sr_o[SR_FD]                 = 1'b0;
            new_sr_o[IMASK_LO +: IMASK_W]   = '1;
        end
    end
endmodule

// File: rtl/entry_save.sv
// Module: entry_save
// Computes the saved PC: rewind for a delay-slot instruction, advance for
// the trap instruction. Assumes fixed-size instructions of STEP bytes.
module entry_save
    import evt_entry_pkg::*;
#(
    parameter int AW   = ADDR_W,
    parameter int CW   = CODE_W,
    parameter int STEP = 2
) (
    input  logic [AW-1:0] pc_i,
    input  logic          in_delay_i,
    input  ev_kind_e      kind_i,
    input  logic [CW-1:0] code_i,
    output logic [AW-1:0] saved_pc_o
);
    logic [AW-1:0] rewind;
    logic [AW-1:0] advance;

    // Adjustment terms, each zero or one instruction step
    always_comb begin
        rewind  = in_delay_i ? AW'(STEP) : '0;
        advance = ((kind_i == EV_EXC) && (code_i == CW'(C_TRAP))) ? AW'(STEP) : '0;
    end

    // Saved PC combines both terms
    assign saved_pc_o = pc_i - rewind + advance;
endmodule

// File: rtl/evt_entry_top.sv
// Module: evt_entry_top
// Exception/interrupt entry sequencer. Registers the outcome of a taken
// event in one edge and strobes accept_o for one cycle; outputs hold
// otherwise. Assumes the core samples outputs while accept_o is high.
module evt_entry_top
    import evt_entry_pkg::*;
#(
    parameter int            AW        = ADDR_W,
    parameter int            CW        = CODE_W,
    parameter logic [AW-1:0] OFS_GEN   = AW'('h100),
    parameter logic [AW-1:0] OFS_MISS  = AW'('h400),
    parameter logic [AW-1:0] OFS_IRQ   = AW'('h600),
    parameter logic [AW-1:0] RESET_VEC = AW'('hA000_0000)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          exc_pending_i,
    input  logic [CW-1:0] exc_code_i,
    input  logic          irq_valid_i,
    input  logic [CW-1:0] irq_vector_i,
    input  logic          sleep_i,
    input  logic          in_delay_slot_i,
    input  logic [AW-1:0] cur_sr_i,
    input  logic [AW-1:0] cur_pc_i,
    input  logic [AW-1:0] vbr_i,
    input  logic [AW-1:0] gpr15_i,
    output logic          accept_o,
    output logic          delay_clr_o,
    output logic [AW-1:0] handler_pc_o,
    output logic [AW-1:0] new_sr_o,
    output logic [AW-1:0] saved_sr_o,
    output logic [AW-1:0] saved_pc_o,
    output logic [AW-1:0] saved_gpr_o,
    output logic [CW-1:0] exc_event_o,
    output logic [CW-1:0] int_event_o,
    output logic          asleep_o
);
    localparam logic [AW-1:0] SR_RESET = (AW'(1) << SR_BL) | (AW'(1) << SR_MD);

    logic          take;
    ev_kind_e      kind;
    logic [CW-1:0] eff_code;
    logic [AW-1:0] nxt_handler;
    logic [AW-1:0] nxt_sr;
    logic [AW-1:0] nxt_spc;

    entry_arbiter #(.CW(CW)) u_arb (
        .exc_pending_i (exc_pending_i),
        .exc_code_i    (exc_code_i),
        .irq_valid_i   (irq_valid_i),
        .blocked_i     (cur_sr_i[SR_BL]),
        .asleep_i      (asleep_o),
        .take_o        (take),
        .kind_o        (kind),
        .code_o        (eff_code)
    );

    entry_target #(
        .AW(AW), .CW(CW), .OFS_GEN(OFS_GEN), .OFS_MISS(OFS_MISS),
        .OFS_IRQ(OFS_IRQ), .RESET_VEC(RESET_VEC)
    ) u_tgt (
        .kind_i    (kind),
        .code_i    (eff_code),
        .vbr_i     (vbr_i),
        .sr_i      (cur_sr_i),
        .handler_o (nxt_handler),
        .new_sr_o  (nxt_sr)
    );

    entry_save #(.AW(AW), .CW(CW), .STEP(2)) u_save (
        .pc_i       (cur_pc_i),
        .in_delay_i (in_delay_slot_i),
        .kind_i     (kind),
        .code_i     (eff_code),
        .saved_pc_o (nxt_spc)
    );

    // Strobes: accept and delay-slot clear last one cycle after a take
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            accept_o    <= 1'b0;
            delay_clr_o <= 1'b0;
        end else begin
            accept_o    <= take;
            delay_clr_o <= take && in_delay_slot_i;
        end
    end

    // Entry state: loaded only on a taken event, held otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            handler_pc_o <= '0;
            new_sr_o     <= SR_RESET;
            saved_sr_o   <= '0;
            saved_pc_o   <= '0;
            saved_gpr_o  <= '0;
        end else if (take) begin
            handler_pc_o <= nxt_handler;
            new_sr_o     <= nxt_sr;
            saved_sr_o   <= cur_sr_i;
            saved_pc_o   <= nxt_spc;
            saved_gpr_o  <= gpr15_i;
        end
    end

    // Event registers: each loaded only by its own kind of event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exc_event_o <= '0;
            int_event_o <= '0;
        end else begin
            if (kind == EV_EXC) exc_event_o <= eff_code;
            if (kind == EV_IRQ) int_event_o <= irq_vector_i;
        end
    end

    // Sleep flag: set by request, cleared by any taken event
    always_ff @(posedge clk) begin
        if (!rst_n)       asleep_o <= 1'b0;
        else if (take)    asleep_o <= 1'b0;
        else if (sleep_i) asleep_o <= 1'b1;
    end

    // R1: exception taken regardless of a concurrent interrupt
    a_r1_exc_first: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_pending_i && !cur_sr_i[SR_BL]) |=>
            (accept_o && exc_event_o == $past(exc_code_i) &&
             int_event_o == $past(int_event_o)));

    // R3: blocked and awake means the interrupt is dropped
    a_r3_blocked_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (!exc_pending_i && irq_valid_i && cur_sr_i[SR_BL] && !asleep_o) |=>
            (!accept_o && $stable(handler_pc_o)));

    // R4: saved copies match the inputs of the capturing cycle
    a_r4_saved_copy: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |-> (saved_sr_o == $past(cur_sr_i) && saved_gpr_o == $past(gpr15_i)));

    // R4: new status always privileged, blocked, bank 1 after an entry
    a_r4_status_bits: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |-> (new_sr_o[SR_BL] && new_sr_o[SR_MD] && new_sr_o[SR_RB]));

    // R10: no event input means no strobe and held outputs
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!exc_pending_i && !irq_valid_i) |=>
            (!accept_o && $stable(handler_pc_o) && $stable(saved_pc_o)));

    // R11: sleep flag is low whenever an entry has just happened
    a_r11_sleep_clear: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |-> !asleep_o);
endmodule

// File: tb/evt_entry_top_test.sv
`timescale 1ns/1ps
module evt_entry_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_pending_i = 1'b0;
    logic [11:0] exc_code_i = '0;
    logic        irq_valid_i = 1'b0;
    logic [11:0] irq_vector_i = '0;
    logic        sleep_i = 1'b0;
    logic        in_delay_slot_i = 1'b0;
    logic [31:0] cur_sr_i = '0, cur_pc_i = '0, vbr_i = '0, gpr15_i = '0;
    logic        accept_o, delay_clr_o, asleep_o;
    logic [31:0] handler_pc_o, new_sr_o, saved_sr_o, saved_pc_o, saved_gpr_o;
    logic [11:0] exc_event_o, int_event_o;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    // model state
    logic [31:0] m_pc = 32'h0, m_sr = 32'h5000_0000, m_ssr = 0, m_spc = 0, m_sgr = 0;
    logic [11:0] m_exc = 0, m_int = 0;
    bit          m_sleep = 0;

    evt_entry_top uut (
        .clk(clk), .rst_n(rst_n), .exc_pending_i(exc_pending_i), .exc_code_i(exc_code_i),
        .irq_valid_i(irq_valid_i), .irq_vector_i(irq_vector_i), .sleep_i(sleep_i),
        .in_delay_slot_i(in_delay_slot_i), .cur_sr_i(cur_sr_i), .cur_pc_i(cur_pc_i),
        .vbr_i(vbr_i), .gpr15_i(gpr15_i), .accept_o(accept_o), .delay_clr_o(delay_clr_o),
        .handler_pc_o(handler_pc_o), .new_sr_o(new_sr_o), .saved_sr_o(saved_sr_o),
        .saved_pc_o(saved_pc_o), .saved_gpr_o(saved_gpr_o), .exc_event_o(exc_event_o),
        .int_event_o(int_event_o), .asleep_o(asleep_o)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic check_held(input string tag);
        chk(accept_o == 1'b0, {tag, " accept"}, 32'(accept_o), 32'h0);
        chk(handler_pc_o == m_pc, {tag, " handler"}, handler_pc_o, m_pc);
        chk(saved_pc_o == m_spc, {tag, " saved_pc"}, saved_pc_o, m_spc);
        chk(int_event_o == m_int, {tag, " int_event"}, 32'(int_event_o), 32'(m_int));
        chk(exc_event_o == m_exc, {tag, " exc_event"}, 32'(exc_event_o), 32'(m_exc));
        chk(asleep_o == m_sleep, {tag, " asleep"}, 32'(asleep_o), 32'(m_sleep));
    endtask

    task automatic fire(input bit ep, input logic [11:0] code, input bit iv, input logic [11:0] vec,
                        input logic [31:0] sr, input logic [31:0] pc, input logic [31:0] vb,
                        input logic [31:0] g, input bit ds);
        bit blk, take, is_exc, rst_cls;
        logic [11:0] ec;
        blk = sr[28];
        is_exc = ep;
        ec = (ep && blk && code != 12'h1E0) ? 12'h000 : code;
        take = ep || (iv && (!blk || m_sleep));
        @(negedge clk);
        exc_pending_i = ep; exc_code_i = code; irq_valid_i = iv; irq_vector_i = vec;
        cur_sr_i = sr; cur_pc_i = pc; vbr_i = vb; gpr15_i = g; in_delay_slot_i = ds;
        @(posedge clk); #1;
        if (take) begin
            rst_cls = is_exc && (ec == 12'h000 || ec == 12'h020 || ec == 12'h140);
            m_ssr = sr; m_sgr = g;
            m_sr = sr | 32'h7000_0000;
            if (rst_cls) begin m_sr[15] = 1'b0; m_sr[7:4] = 4'hF; end
            m_spc = pc - (ds ? 32'd2 : 32'd0) + ((is_exc && ec == 12'h160) ? 32'd2 : 32'd0);
            if (!is_exc) m_pc = vb + 32'h600;
            else if (rst_cls) m_pc = 32'hA000_0000;
            else if (ec == 12'h040 || ec == 12'h060) m_pc = vb + 32'h400;
            else m_pc = vb + 32'h100;
            if (is_exc) m_exc = ec; else m_int = vec;
            m_sleep = 0;
            chk(accept_o == 1'b1, "R10 accept strobe", 32'(accept_o), 32'h1);
            chk(handler_pc_o == m_pc, "R6/R7 handler address", handler_pc_o, m_pc);
            chk(new_sr_o == m_sr, "R4/R6 new status", new_sr_o, m_sr);
            chk(saved_sr_o == m_ssr, "R4 saved status", saved_sr_o, m_ssr);
            chk(saved_gpr_o == m_sgr, "R4 saved gpr15", saved_gpr_o, m_sgr);
            chk(saved_pc_o == m_spc, "R5/R8 saved pc", saved_pc_o, m_spc);
            chk(delay_clr_o == ds, "R5 delay clear", 32'(delay_clr_o), 32'(ds));
            chk(exc_event_o == m_exc, "R1/R2/R9 exc event", 32'(exc_event_o), 32'(m_exc));
            chk(int_event_o == m_int, "R1/R9 int event", 32'(int_event_o), 32'(m_int));
            chk(asleep_o == 1'b0, "R11 sleep cleared", 32'(asleep_o), 32'h0);
        end else begin
            check_held("R3 blocked interrupt");
        end
        @(negedge clk);
        exc_pending_i = 0; irq_valid_i = 0; in_delay_slot_i = 0;
        @(posedge clk); #1;
        check_held("R10 hold after event");
    endtask

    task automatic go_sleep;
        @(negedge clk); sleep_i = 1'b1;
        @(posedge clk); #1;
        m_sleep = 1;
        chk(asleep_o == 1'b1, "R11 sleep set", 32'(asleep_o), 32'h1);
        @(negedge clk); sleep_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R12 reset values
        chk(accept_o == 0 && delay_clr_o == 0, "R12 strobes at reset", 32'(accept_o), 32'h0);
        chk(new_sr_o == 32'h5000_0000, "R12 status at reset", new_sr_o, 32'h5000_0000);
        chk(handler_pc_o == 0 && saved_pc_o == 0, "R12 pc regs at reset", handler_pc_o, 32'h0);
        chk(saved_sr_o == 0 && saved_gpr_o == 0, "R12 saved regs at reset", saved_sr_o, 32'h0);
        chk(exc_event_o == 0 && int_event_o == 0, "R12 events at reset", 32'(exc_event_o), 32'h0);
        chk(asleep_o == 0, "R12 sleep at reset", 32'(asleep_o), 32'h0);
        @(negedge clk); rst_n = 1'b1;

        // exception sweep over block bit, delay slot and aligned codes
        for (int bl = 0; bl < 2; bl++)
            for (int ds = 0; ds < 2; ds++)
                for (int k = 0; k < 128; k++) begin
                    logic [31:0] sr;
                    sr = (32'(bl) << 28) | 32'h0000_8001 | (32'(k % 16) << 4);
                    fire(1'b1, 12'(k * 32), k[0], 12'h3A0 + 12'(k), sr,
                         32'h0C00_1000 + 32'(k * 8), 32'h8C00_0000 + (32'(k) << 12),
                         32'h1234_0000 + 32'(k), ds[0]);
                end

        // interrupts across block bit and sleep
        fire(1'b0, 12'h0, 1'b1, 12'h200, 32'h0000_80F0, 32'h0C00_2000, 32'h8C01_0000, 32'hA5A5_0001, 1'b0);
        fire(1'b0, 12'h0, 1'b1, 12'h220, 32'h1000_8030, 32'h0C00_2100, 32'h8C02_0000, 32'hA5A5_0002, 1'b0);
        go_sleep();
        fire(1'b0, 12'h0, 1'b1, 12'h240, 32'h1000_8030, 32'h0C00_2200, 32'h8C03_0000, 32'hA5A5_0003, 1'b1);
        go_sleep();
        fire(1'b0, 12'h0, 1'b1, 12'h260, 32'h0000_0000, 32'h0C00_2300, 32'h8C04_0000, 32'hA5A5_0004, 1'b0);
        go_sleep();
        fire(1'b1, 12'h160, 1'b1, 12'h280, 32'h0000_0010, 32'h0C00_2400, 32'h8C05_0000, 32'hA5A5_0005, 1'b0);
        fire(1'b0, 12'h0, 1'b1, 12'h2A0, 32'h1000_0000, 32'h0C00_2500, 32'h8C06_0000, 32'hA5A5_0006, 1'b0);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            nchk++;
            nfail++;
            $display("FAIL watchdog act=%h exp=%h", 32'h1, 32'h0);
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end
endmodule